// File: doc/BRIEF.md
# Bit-Plane Binary Encoder for the First Network Layer

This block lets a binary network take raw 8-bit pixels directly, so the input layer needs no full-precision convolution. Each transaction delivers one 3x3 window of pixels. The block slices the window into binary bit-planes, one plane per pixel bit. It compares every plane against a binary kernel of its own and counts the matching taps, which is the XNOR-popcount form. It scales each plane's score by a signed weight of its own and adds the scaled scores. The sign of the total is the single feature bit.

Software loads the kernel and weight for each plane through a one-cycle write port. The planes are worked through one per clock, starting with the most significant bit, so a result takes a fixed number of cycles after a window is accepted. The full-width fused sum is also presented next to the feature bit, so a downstream stage can use the pre-activation value when it needs it.

Top module: `bitplane_encoder`

## Requirements
- R1: After reset, out_valid_o is low, in_ready_o is high and out_sum_o is zero. Every plane kernel and weight resets to zero, so the first window gives a sum of 0.
- R2: Configuration index i, for i from 0 to P-1, controls pixel bit 7-i. When P is less than 8, only the upper P pixel bits affect the result.
- R3: Tap t is window_i[8t+7:8t], and kernel bit t is paired with tap t. A plane's score is 2*m-9, where m counts the taps whose plane bit equals the kernel bit.
- R4: out_sum_o is the sum over the planes of weight_i*score_i. The weights are 8-bit two's complement. out_sum_o is two's complement and wide enough for plus or minus 9*128*P without overflow.
- R5: out_bit_o is 1 when the fused sum is zero or positive and 0 when it is negative.
- R6: out_valid_o is a one-cycle pulse exactly P+1 cycles after the accepting clock edge. Each accepted window produces exactly one pulse.
- R7: in_ready_o is low from the accepting edge until the result is issued. in_valid_i is ignored while in_ready_o is low. The window is captured when it is accepted, so later changes on window_i do not affect the result.
- R8: When cfg_we_i is high, the kernel and weight of plane cfg_plane_i are written at that clock edge. A write to an index of P or above is ignored.
- R9: Between pulses, out_sum_o and out_bit_o keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Window offered |
| in_ready_o | output | 1 | Block idle, window will be accepted |
| window_i | input | 72 | Nine 8-bit pixels, tap t at bits 8t+7:8t |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_plane_i | input | 3 | Plane index to write (0 = most significant bit) |
| cfg_kernel_i | input | 9 | Binary kernel, bit t for tap t |
| cfg_weight_i | input | 8 | Signed plane weight |
| out_valid_o | output | 1 | Result pulse |
| out_bit_o | output | 1 | Binary feature |
| out_sum_o | output | ACC_W (18 at P=8) | Fused signed sum |

## Verification
The bench sets every weight to -128 and presents windows of all-ones and all-zeros. This drives the sum to its largest positive and negative values, where a narrow accumulator would wrap and invert the feature bit. The all-zero reset configuration gives a sum of exactly zero, which catches a sign test that sends zero to 0. A second instance with three planes, together with writes to plane index 3, exposes a design that takes the wrong bit order or that accepts out-of-range writes. The bench holds in_valid_i high with changing data while the block is busy. A design that accepts windows early or reads window_i live would then emit extra pulses or wrong sums.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  localparam int unsigned TAPS = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ISSUE = 2'd2
  } bpe_state_e;
endpackage

// File: rtl/bpe_cfg_regs.sv
module bpe_cfg_regs
  import bpe_pkg::*;
#(
  parameter int unsigned P     = 8,
  parameter int unsigned WT_W  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [TAPS-1:0]       kernel_i,
  input  logic [WT_W-1:0]       weight_i,
  output logic [P*TAPS-1:0]     kernel_o,
  output logic [P*WT_W-1:0]     weight_o
);

  for (genvar g = 0; g < P; g++) begin : g_plane
    logic [TAPS-1:0] k_q;
    logic [WT_W-1:0] w_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        k_q <= '0;
        w_q <= '0;
      end else if (we_i && (int'(idx_i) == g)) begin
        k_q <= kernel_i;
        w_q <= weight_i;
      end
    end

    assign kernel_o[g*TAPS +: TAPS] = k_q;
    assign weight_o[g*WT_W +: WT_W] = w_q;
  end

  assert_cfg_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (int'(idx_i) >= int'(P))) |=> ($stable(kernel_o) && $stable(weight_o)));

  assert_cfg_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (int'(idx_i) < int'(P))) |=>
      (kernel_o[int'($past(idx_i))*TAPS +: TAPS] == $past(kernel_i)));

endmodule

// File: rtl/bpe_plane_term.sv
module bpe_plane_term
  import bpe_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned P      = 8,
  parameter int unsigned WT_W   = 8,
  parameter int unsigned PW     = 3,
  parameter int unsigned SC_W   = 6,
  parameter int unsigned PROD_W = 14
) (
  input  logic [TAPS*PIX_W-1:0]     window_i,
  input  logic [PW-1:0]             plane_i,
  input  logic [P*TAPS-1:0]         kernels_i,
  input  logic [P*WT_W-1:0]         weights_i,
  output logic signed [PROD_W-1:0]  term_o
);

  localparam int unsigned BW    = (PIX_W > 1) ? $clog2(PIX_W) : 1;
  localparam int unsigned CNT_W = $clog2(TAPS + 1);

  logic [BW-1:0]             bit_sel;
  logic [TAPS-1:0]           plane_bits;
  logic [TAPS-1:0]           kern;
  logic [TAPS-1:0]           agree;
  logic [CNT_W-1:0]          pop;
  logic signed [SC_W-1:0]    score;
  logic signed [WT_W-1:0]    wt;
  logic signed [PROD_W-1:0]  score_x;
  logic signed [PROD_W-1:0]  wt_x;

  // plane 0 is the pixel MSB
  assign bit_sel = BW'(int'(PIX_W) - 1 - int'(plane_i));

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign plane_bits[t] = window_i[t*PIX_W + int'(bit_sel)];
  end

  assign kern  = kernels_i[int'(plane_i)*TAPS +: TAPS];
  assign wt    = weights_i[int'(plane_i)*WT_W +: WT_W];
  assign agree = ~(plane_bits ^ kern);

  always_comb begin
    pop = '0;
    for (int t = 0; t < TAPS; t++) pop = pop + CNT_W'(agree[t]);
  end

  assign score   = SC_W'({1'b0, pop, 1'b0}) - SC_W'(TAPS);
  assign score_x = PROD_W'(score);
  assign wt_x    = PROD_W'(wt);
  assign term_o  = score_x * wt_x;

endmodule

// File: rtl/bpe_seq.sv
module bpe_seq
  import bpe_pkg::*;
#(
  parameter int unsigned P      = 8,
  parameter int unsigned PROD_W = 14,
  parameter int unsigned ACC_W  = 18,
  parameter int unsigned PW     = 3,
  parameter int unsigned WT_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  output logic                     load_o,
  output logic [PW-1:0]            plane_o,
  input  logic signed [PROD_W-1:0] term_i,
  output logic                     out_valid_o,
  output logic                     out_bit_o,
  output logic [ACC_W-1:0]         out_sum_o
);

  localparam logic [PW-1:0] LAST  = PW'(P - 1);
  localparam int unsigned   LAT_W = $clog2(P + 3) + 1;
  localparam int            TMAX  = 9 * (2 ** (WT_W - 1));

  bpe_state_e              state_q;
  logic [PW-1:0]           cnt_q;
  logic [ACC_W-1:0]        acc_q;
  logic [ACC_W-1:0]        term_x;

  assign in_ready_o = (state_q == ST_IDLE);
  assign load_o     = in_ready_o & in_valid_i;
  assign plane_o    = cnt_q;
  assign term_x     = {{(ACC_W-PROD_W){term_i[PROD_W-1]}}, term_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_bit_o   <= 1'b0;
      out_sum_o   <= '0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          acc_q   <= '0;
        end
        ST_RUN: begin
          acc_q <= acc_q + term_x;
          if (cnt_q == LAST) state_q <= ST_ISSUE;
          else               cnt_q   <= cnt_q + PW'(1);
        end
        ST_ISSUE: begin
          out_valid_o <= 1'b1;
          out_sum_o   <= acc_q;
          out_bit_o   <= ~acc_q[ACC_W-1];  // zero counts as positive
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // latency tracker for the checks below
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lat_q <= '0;
    else if (load_o)         lat_q <= LAT_W'(1);
    else if (out_valid_o)    lat_q <= '0;
    else if (lat_q != '0)    lat_q <= lat_q + LAT_W'(1);
  end

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(lat_q) == int'(P) + 2));

  assert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !in_ready_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_ISSUE) |=> ($stable(out_sum_o) && $stable(out_bit_o)));

  assert_term_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> ((int'(term_i) <= TMAX) && (int'(term_i) >= -TMAX)));

endmodule

// File: rtl/bitplane_encoder.sv
module bitplane_encoder
  import bpe_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned P     = 8,
  parameter int unsigned WT_W  = 8,
  localparam int unsigned IDX_W  = (PIX_W > 1) ? $clog2(PIX_W) : 1,
  localparam int unsigned SC_W   = $clog2(TAPS + 1) + 2,
  localparam int unsigned PROD_W = WT_W + SC_W,
  localparam int unsigned ACC_W  = PROD_W + $clog2(P) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [TAPS*PIX_W-1:0]   window_i,
  input  logic                    cfg_we_i,
  input  logic [IDX_W-1:0]        cfg_plane_i,
  input  logic [TAPS-1:0]         cfg_kernel_i,
  input  logic [WT_W-1:0]         cfg_weight_i,
  output logic                    out_valid_o,
  output logic                    out_bit_o,
  output logic [ACC_W-1:0]        out_sum_o
);

  localparam int unsigned PW = (P > 1) ? $clog2(P) : 1;

  initial begin
    if (P < 1 || P > PIX_W) $error("plane count out of range");
  end

  logic [P*TAPS-1:0]        kernels;
  logic [P*WT_W-1:0]        weights;
  logic [TAPS*PIX_W-1:0]    win_q;
  logic                     load;
  logic [PW-1:0]            plane;
  logic signed [PROD_W-1:0] term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   win_q <= '0;
    else if (load) win_q <= window_i;
  end

  bpe_cfg_regs #(.P(P), .WT_W(WT_W), .IDX_W(IDX_W)) cfg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .idx_i    (cfg_plane_i),
    .kernel_i (cfg_kernel_i),
    .weight_i (cfg_weight_i),
    .kernel_o (kernels),
    .weight_o (weights)
  );

  bpe_plane_term #(
    .PIX_W(PIX_W), .P(P), .WT_W(WT_W), .PW(PW), .SC_W(SC_W), .PROD_W(PROD_W)
  ) term_i (
    .window_i  (win_q),
    .plane_i   (plane),
    .kernels_i (kernels),
    .weights_i (weights),
    .term_o    (term)
  );

  bpe_seq #(
    .P(P), .PROD_W(PROD_W), .ACC_W(ACC_W), .PW(PW), .WT_W(WT_W)
  ) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .plane_o     (plane),
    .term_i      (term),
    .out_valid_o (out_valid_o),
    .out_bit_o   (out_bit_o),
    .out_sum_o   (out_sum_o)
  );

  assert_window_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> $stable(win_q));

endmodule

// File: tb/bitplane_encoder_tb_top.sv
module bitplane_encoder_tb_top;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  logic        valid_a = 0, valid_b = 0;
  logic [71:0] window = '0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = '0;
  logic [8:0]  cfg_k = '0;
  logic [7:0]  cfg_w = '0;
  logic        ready_a, ready_b, ov_a, ov_b, ob_a, ob_b;
  logic [17:0] os_a;
  logic [16:0] os_b;

  bitplane_encoder #(.P(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(valid_a), .in_ready_o(ready_a),
    .window_i(window), .cfg_we_i(cfg_we), .cfg_plane_i(cfg_idx),
    .cfg_kernel_i(cfg_k), .cfg_weight_i(cfg_w),
    .out_valid_o(ov_a), .out_bit_o(ob_a), .out_sum_o(os_a)
  );

  bitplane_encoder #(.P(3)) dut_p3_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(valid_b), .in_ready_o(ready_b),
    .window_i(window), .cfg_we_i(cfg_we), .cfg_plane_i(cfg_idx),
    .cfg_kernel_i(cfg_k), .cfg_weight_i(cfg_w),
    .out_valid_o(ov_b), .out_bit_o(ob_b), .out_sum_o(os_b)
  );

  int checks = 0, errors = 0;
  bit armed = 0;
  logic [8:0]        mk_a [8], mk_b [8];
  logic signed [7:0] mw_a [8], mw_b [8];
  int due_a[$], exp_a[$], due_b[$], exp_b[$];
  int last_a = 0, last_b = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(logic [71:0] w, int np, logic [8:0] k [8],
                               logic signed [7:0] wt [8]);
    int s;
    s = 0;
    for (int p = 0; p < np; p++) begin
      int m;
      m = 0;
      for (int t = 0; t < 9; t++) if (w[t*8 + 7 - p] == k[p][t]) m++;
      s += int'(wt[p]) * (2*m - 9);
    end
    return s;
  endfunction

  // reference comparison on every clock
  always @(negedge clk_i) begin
    int sa, sb;
    if (armed) begin
      sa = int'($signed(os_a));
      sb = int'($signed(os_b));
      if (due_a.size() > 0 && due_a[0] == cyc) begin
        check(ov_a == 1'b1, "R6 P8 valid", int'(ov_a), 1);
        check(sa == exp_a[0], "R4 P8 sum", sa, exp_a[0]);
        check(ob_a == (exp_a[0] >= 0), "R5 P8 bit", int'(ob_a), int'(exp_a[0] >= 0));
        last_a = sa;
        void'(due_a.pop_front()); void'(exp_a.pop_front());
      end else begin
        check(ov_a == 1'b0, "R6 P8 spurious valid", int'(ov_a), 0);
        check(sa == last_a, "R9 P8 hold", sa, last_a);
      end
      if (due_b.size() > 0 && due_b[0] == cyc) begin
        check(ov_b == 1'b1, "R6 P3 valid", int'(ov_b), 1);
        check(sb == exp_b[0], "R4 P3 sum", sb, exp_b[0]);
        check(ob_b == (exp_b[0] >= 0), "R5 P3 bit", int'(ob_b), int'(exp_b[0] >= 0));
        last_b = sb;
        void'(due_b.pop_front()); void'(exp_b.pop_front());
      end else begin
        check(ov_b == 1'b0, "R6 P3 spurious valid", int'(ov_b), 0);
        check(sb == last_b, "R9 P3 hold", sb, last_b);
      end
    end
  end

  // offer a window; junk is driven while either block is busy (R7)
  task automatic send(logic [71:0] w);
    bit done;
    logic [95:0] junk;
    done = 0;
    while (!done) begin
      @(negedge clk_i);
      cfg_we = 0;
      if (ready_a && ready_b) begin
        valid_a = 1; valid_b = 1; window = w;
        due_a.push_back(cyc + 10); exp_a.push_back(model(w, 8, mk_a, mw_a));
        due_b.push_back(cyc + 5);  exp_b.push_back(model(w, 3, mk_b, mw_b));
        done = 1;
      end else begin
        junk = {$urandom(), $urandom(), $urandom()};
        window = junk[71:0];
        valid_a = 1;
        valid_b = !ready_b;
      end
    end
  endtask

  task automatic quiesce();
    do begin
      @(negedge clk_i);
      valid_a = 0; valid_b = 0; cfg_we = 0;
    end while (!(ready_a && ready_b && due_a.size() == 0 && due_b.size() == 0));
  endtask

  task automatic cfg(int idx, logic [8:0] k, logic signed [7:0] w);
    quiesce();
    cfg_we = 1; cfg_idx = 3'(idx); cfg_k = k; cfg_w = w;
    if (idx < 8) begin mk_a[idx] = k; mw_a[idx] = w; end
    if (idx < 3) begin mk_b[idx] = k; mw_b[idx] = w; end
    @(negedge clk_i);
    cfg_we = 0;
  endtask

  task automatic expect_last(int ea, int eb, string tag);
    quiesce();
    check(last_a == ea, {tag, " P8 directed"}, last_a, ea);
    check(last_b == eb, {tag, " P3 directed"}, last_b, eb);
    check(ob_a == (ea >= 0), {tag, " P8 bit"}, int'(ob_a), int'(ea >= 0));
    check(ob_b == (eb >= 0), {tag, " P3 bit"}, int'(ob_b), int'(eb >= 0));
  endtask

  function automatic logic [71:0] fill(logic [7:0] px);
    logic [71:0] w;
    for (int t = 0; t < 9; t++) w[t*8 +: 8] = px;
    return w;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [71:0] w;
    for (int i = 0; i < 8; i++) begin
      mk_a[i] = '0; mw_a[i] = '0; mk_b[i] = '0; mw_b[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(ov_a == 0 && ov_b == 0, "R1 valid low in reset", int'(ov_a | ov_b), 0);
    check(ready_a && ready_b, "R1 ready high in reset", int'(ready_a & ready_b), 1);
    check(os_a == '0, "R1 sum zero in reset", int'($signed(os_a)), 0);
    rst_ni = 1;
    @(negedge clk_i);
    armed = 1;

    // R1/R5: zero configuration gives sum 0 and bit 1
    send(72'h0123456789abcdef55);
    expect_last(0, 0, "R5 zero sum");

    // R2: only MSB plane weighted; taps 0..4 MSB=1, taps 5..8 MSB=0
    cfg(0, 9'h1FF, 8'sd1);
    for (int t = 0; t < 9; t++) w[t*8 +: 8] = (t < 5) ? 8'h80 : 8'h7F;
    send(w);
    expect_last(1, 1, "R2 msb plane");

    // R2/R8: index 3 reaches bit 4 on P=8, ignored on P=3
    cfg(3, 9'h000, 8'sd100);
    send(w);
    expect_last(101, 1, "R8 out of range write");

    // R4 extremes
    for (int i = 0; i < 8; i++) cfg(i, 9'h000, -8'sd128);
    send(fill(8'hFF));
    expect_last(9216, 3456, "R4 positive extreme");
    send(fill(8'h00));
    expect_last(-9216, -3456, "R4 negative extreme");

    // R3: kernel pattern against checkerboard-like window
    cfg(0, 9'b101010101, 8'sd3);
    cfg(1, 9'b111100000, -8'sd5);
    send(72'hFF00FF00FF00FF00FF);
    expect_last(model(72'hFF00FF00FF00FF00FF, 8, mk_a, mw_a),
                model(72'hFF00FF00FF00FF00FF, 3, mk_b, mw_b), "R3 pattern");

    // random traffic, back-to-back with busy-time junk (R7)
    for (int n = 0; n < 200; n++) begin
      logic [95:0] r;
      if (n % 16 == 0) cfg($urandom_range(0, 7), 9'($urandom()), 8'($urandom()));
      r = {$urandom(), $urandom(), $urandom()};
      send(r[71:0]);
    end
    quiesce();
    check(due_a.size() == 0, "R6 P8 all results issued", due_a.size(), 0);
    check(due_b.size() == 0, "R6 P3 all results issued", due_b.size(), 0);
    finish_run();
  end

endmodule